// File: doc/BRIEF.md
# Reload-and-Compare PWM Timer

This block generates a single pulse-width-modulated output from an up-counter that wraps to a programmable reload value instead of to zero. On every wrap past the all-ones value, the counter takes the reload value and the output goes to its active level. When the counter reaches the compare value, the output goes to its inactive level. The reload value therefore sets the period, and the distance from reload to compare sets the active time. Both sit near the top of the count range.

Software programs the block through write strobes. There are strobes for the reload value, the compare value, the counter itself, and a control word. The control word carries run/stop, output inversion and an optional power-of-two tick prescaler. Before each start, software presets the counter to all-ones minus one, so that the first wrap and compare events toggle the output at once. Reload and compare writes take effect on the next clock, not at a period boundary. Two status outputs report whether the timer runs and which polarity is in force.

Top module: `pwm_reload_timer`

## Requirements
- R1: After a synchronous reset the timer is stopped, the counter, reload and compare values are zero, polarity is normal (`sts_invert`=0) and `pwm_out` is 0.
- R2: A counter write (`cnt_we`) loads `wdata` into the counter when the timer is stopped. When the timer is running, the write is ignored and the counter keeps advancing.
- R3: While running, a tick with the counter at all-ones (MAX) loads the reload value and drives the output active. One period is MAX − reload + 1 ticks.
- R4: A tick with the counter equal to the compare value drives the output inactive. The active phase is compare − reload + 1 ticks and the inactive phase is MAX − compare ticks, for reload ≤ compare < MAX.
- R5: After a preset to MAX − 1 and a start, the output first reaches its active level on the second tick. Without prescaling, that is three clock edges counted from and including the start edge.
- R6: A stop takes effect on its own clock edge. The counter freezes without finishing the period, and `pwm_out` returns to its idle level.
- R7: The idle and inactive output level equals `sts_invert`, and the active level is its complement. Inversion is taken from a control write only while the timer is stopped. While running, the inversion field is ignored.
- R8: Reload and compare writes take effect on the next clock, including mid-period. A compare write made during the active phase ends that phase when the counter reaches the new value.
- R9: With `ctl_pre_en`=1, one tick occurs every 2^(`ctl_pre_div`+1) clocks, so all phase lengths scale by that factor. With `ctl_pre_en`=0, one tick occurs every clock. The prescaler fields are taken only while the timer is stopped.
- R10: `sts_started` is 1 exactly while the timer runs. It follows `ctl_run` of the last control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_we | input | 1 | Write `wdata` to the reload value |
| mt_we | input | 1 | Write `wdata` to the compare value |
| cnt_we | input | 1 | Write `wdata` to the counter (stopped only) |
| wdata | input | CNT_W | Write data for the three value strobes |
| ctl_we | input | 1 | Write the control fields below |
| ctl_run | input | 1 | 1 = run, 0 = stop |
| ctl_inv | input | 1 | 1 = inverted output polarity |
| ctl_pre_en | input | 1 | 1 = prescaler enabled |
| ctl_pre_div | input | PSC_W | Prescaler exponent N, tick every 2^(N+1) clocks |
| pwm_out | output | 1 | PWM output |
| sts_started | output | 1 | Timer is running |
| sts_invert | output | 1 | Inversion in force |
| cnt_value | output | CNT_W | Current counter value |

## Verification
Every write is registered, so the counter, status and `pwm_out` show a write after the clock edge that captures it. The bench therefore samples shortly after each rising edge and drives inputs on falling edges. Phase lengths are counted in whole sampled cycles between level changes and compared with the R4 formulas, scaled by the prescale factor. Start latency is counted from the start edge: three edges without prescaling, 2D + 1 edges with a divisor D. A compare write made mid-active-phase to the counter value plus two must end the phase three edges after the write edge.

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_we,
  input  logic             mt_we,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic             ctl_inv,
  input  logic             ctl_pre_en,
  input  logic [PSC_W-1:0] ctl_pre_div,
  output logic             pwm_out,
  output logic             sts_started,
  output logic             sts_invert,
  output logic [CNT_W-1:0] cnt_value
);
  localparam int PC_W = 2 ** PSC_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, load_q, match_q;
  logic             run_q, inv_q, act_q, pre_en_q;
  logic [PSC_W-1:0] pre_div_q;
  logic [PC_W-1:0]  psc_q;
  logic [PC_W:0]    psc_span;
  logic [PC_W-1:0]  psc_lim;
  logic             tick, stop_now;

  assign psc_span = ({{(PC_W-1){1'b0}}, 2'b10} << pre_div_q) - 1'b1;
  assign psc_lim  = psc_span[PC_W-1:0];
  assign stop_now = ctl_we && !ctl_run;
  assign tick     = run_q && !stop_now && (!pre_en_q || psc_q == psc_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      load_q    <= '0;
      match_q   <= '0;
      run_q     <= 1'b0;
      inv_q     <= 1'b0;
      act_q     <= 1'b0;
      pre_en_q  <= 1'b0;
      pre_div_q <= '0;
      psc_q     <= '0;
    end else begin
      if (ld_we) load_q <= wdata;
      if (mt_we) match_q <= wdata;

      if (ctl_we) begin
        run_q <= ctl_run;
        if (!run_q) begin
          inv_q     <= ctl_inv;
          pre_en_q  <= ctl_pre_en;
          pre_div_q <= ctl_pre_div;
        end
      end

      if (!run_q || stop_now) psc_q <= '0;
      else if (pre_en_q) psc_q <= (psc_q == psc_lim) ? '0 : psc_q + 1'b1;

      if (!run_q && cnt_we) cnt_q <= wdata;
      else if (tick) cnt_q <= (cnt_q == CNT_MAX) ? load_q : cnt_q + 1'b1;

      if (!run_q || stop_now) act_q <= 1'b0;
      else if (tick) begin
        if (cnt_q == CNT_MAX) act_q <= 1'b1;
        else if (cnt_q == match_q) act_q <= 1'b0;
      end
    end
  end

  assign pwm_out     = act_q ^ inv_q;
  assign sts_started = run_q;
  assign sts_invert  = inv_q;
  assign cnt_value   = cnt_q;
endmodule

// File: rtl/pwm_reload_timer_chk.sv
module pwm_reload_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_we,
  input logic             ctl_we,
  input logic             ctl_run,
  input logic             tick,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] match_q,
  input logic             pwm_out,
  input logic             sts_started,
  input logic             sts_invert,
  input logic [CNT_W-1:0] cnt_value
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
    !sts_started |-> pwm_out == sts_invert);

  assert_pol_locked_R7: assert property (@(posedge clk) disable iff (rst)
    sts_started |=> $stable(sts_invert));

  assert_frozen_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    (!sts_started && !cnt_we) |=> $stable(cnt_value));

  assert_cnt_wr_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (sts_started && cnt_we && !tick) |=> $stable(cnt_value));

  assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_value == CNT_MAX) |=> cnt_value == $past(load_q));

  assert_set_on_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_value == CNT_MAX) |=> (!sts_started || pwm_out != sts_invert));

  assert_clear_on_match_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_value == match_q && cnt_value != CNT_MAX) |=> pwm_out == sts_invert);

  assert_stop_now_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !ctl_run) |=> (!sts_started && pwm_out == sts_invert));
endmodule

bind pwm_reload_timer pwm_reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_we(cnt_we), .ctl_we(ctl_we), .ctl_run(ctl_run),
  .tick(tick), .load_q(load_q), .match_q(match_q), .pwm_out(pwm_out),
  .sts_started(sts_started), .sts_invert(sts_invert), .cnt_value(cnt_value)
);

// File: tb/tb_pwm_reload_timer.sv
module tb_pwm_reload_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int MAXV = 255;

  logic clk = 1'b0, rst = 1'b1;
  logic ld_we = 0, mt_we = 0, cnt_we = 0, ctl_we = 0;
  logic ctl_run = 0, ctl_inv = 0, ctl_pre_en = 0;
  logic [2:0] ctl_pre_div = '0;
  logic [W-1:0] wdata = '0;
  logic pwm_out, sts_started, sts_invert;
  logic [W-1:0] cnt_value;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic act_lvl = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_reload_timer #(.CNT_W(W), .PSC_W(3)) dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .mt_we(mt_we), .cnt_we(cnt_we),
    .wdata(wdata), .ctl_we(ctl_we), .ctl_run(ctl_run), .ctl_inv(ctl_inv),
    .ctl_pre_en(ctl_pre_en), .ctl_pre_div(ctl_pre_div), .pwm_out(pwm_out),
    .sts_started(sts_started), .sts_invert(sts_invert), .cnt_value(cnt_value)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_val(int which, int v);
    @(negedge clk);
    wdata = W'(v);
    ld_we = (which == 0); mt_we = (which == 1); cnt_we = (which == 2);
    step();
    ld_we = 0; mt_we = 0; cnt_we = 0;
  endtask

  task automatic wr_ctl(bit run, bit inv, bit pe, int div);
    @(negedge clk);
    ctl_we = 1; ctl_run = run; ctl_inv = inv; ctl_pre_en = pe; ctl_pre_div = 3'(div);
    step();
    ctl_we = 0;
  endtask

  function automatic int div_of(bit pe, int div);
    return pe ? (2 << div) : 1;
  endfunction

  task automatic cfg_start(int ld, int mt, bit inv, bit pe, int div, string req);
    int n;
    wr_ctl(0, inv, pe, div);
    wr_val(0, ld);
    wr_val(1, mt);
    wr_val(2, MAXV - 1);
    act_lvl = !inv;
    wr_ctl(1, inv, pe, div);
    n = 1;
    while (pwm_out !== act_lvl) begin step(); n++; end
    chk(req, n, 2 * div_of(pe, div) + 1);
  endtask

  task automatic measure(int hi, int lo, string req);
    int n;
    while (pwm_out === act_lvl) step();
    while (pwm_out !== act_lvl) step();
    n = 0;
    while (pwm_out === act_lvl) begin n++; step(); end
    chk({req, " active"}, n, hi);
    n = 0;
    while (pwm_out !== act_lvl) begin n++; step(); end
    chk({req, " inactive"}, n, lo);
  endtask

  initial begin
    int c;
    void'($urandom(32'd20240517));
    repeat (3) step();
    rst = 0;
    step();
    chk("R1 pwm_out", int'(pwm_out), 0);
    chk("R1 started", int'(sts_started), 0);
    chk("R1 invert", int'(sts_invert), 0);
    chk("R1 counter", int'(cnt_value), 0);

    wr_val(2, 8'h5A);
    chk("R2 stopped counter write", int'(cnt_value), 'h5A);

    cfg_start(200, 220, 0, 0, 0, "R5 first active edge");
    chk("R10 started", int'(sts_started), 1);
    measure(21, 35, "R4 R3 directed");

    step();
    c = int'(cnt_value);
    wr_val(2, 8'h10);
    chk("R2 running counter write ignored", int'(cnt_value), (c == MAXV) ? 200 : c + 1);

    wr_ctl(1, 1, 0, 0);
    chk("R7 invert ignored while running", int'(sts_invert), 0);

    while (int'(cnt_value) != 205) step();
    @(negedge clk);
    wdata = W'(207); mt_we = 1;
    step(); mt_we = 0;
    c = 1;
    while (pwm_out === act_lvl) begin step(); c++; end
    chk("R8 immediate compare edges", c, 3);

    while (pwm_out !== act_lvl) step();
    wr_ctl(0, 0, 0, 0);
    chk("R6 idle after stop", int'(pwm_out), 0);
    chk("R10 stopped", int'(sts_started), 0);
    c = int'(cnt_value);
    repeat (5) step();
    chk("R6 counter frozen", int'(cnt_value), c);

    wr_ctl(0, 1, 0, 0);
    chk("R7 invert taken when stopped", int'(sts_invert), 1);
    chk("R7 idle level inverted", int'(pwm_out), 1);
    cfg_start(230, 240, 1, 0, 0, "R7 R5 inverted start");
    measure(11, 15, "R7 inverted widths");

    wr_ctl(0, 0, 0, 0);
    cfg_start(240, 245, 0, 1, 1, "R9 prescaled start");
    measure(6 * 4, 10 * 4, "R9 prescaled widths");

    wr_ctl(0, 0, 0, 0);
    cfg_start(254, 254, 0, 0, 0, "R5 minimum period start");
    measure(1, 1, "R3 minimum period");
    wr_ctl(0, 0, 0, 0);
    cfg_start(246, 254, 0, 0, 0, "R5 maximum duty start");
    measure(9, 1, "R4 maximum duty");

    for (int i = 0; i < 8; i++) begin
      int per, duty, ld, mt, div;
      bit pe, inv;
      per  = 2 + int'($urandom_range(0, 38));
      duty = 1 + int'($urandom_range(0, per - 2));
      ld   = MAXV - per + 1;
      mt   = ld + duty - 1;
      pe   = 1'($urandom_range(0, 1));
      div  = int'($urandom_range(0, 2));
      inv  = 1'($urandom_range(0, 1));
      wr_ctl(0, inv, pe, div);
      cfg_start(ld, mt, inv, pe, div, "R9 R5 random start");
      measure(duty * div_of(pe, div), (per - duty) * div_of(pe, div), "R4 R9 random");
    end

    finish_run();
  end
endmodule